// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the addresses of a four-beat burst on a synchronous burst memory. When a burst begins, either the processor-side or the controller-side strobe captures a complete starting address. On each following cycle in which the advance input is high, the block steps to the next beat. Only the two low address bits change during a burst. They wrap inside a four-location window, and every bit above them keeps the value captured at load.

A static order input selects one of two orderings. Linear order counts upward from the start. Interleaved order XORs the start with the beat number. The block also drives a flag that is high while the final beat of the window is on the bus. The memory array, chip-select decoding and data path are outside this block. The order input must stay unchanged for the length of a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, addr_out is all zeros and last_beat is low.
- R2: A clock edge at which ld_cpu or ld_ctl is high puts start_addr unchanged on addr_out right after that edge, and sets the burst to beat 0.
- R3: With order_sel = 0 (linear), the two low bits of addr_out at beat n are (start + n) mod 4.
- R4: With order_sel = 1 (interleaved), the two low bits of addr_out at beat n are start XOR n.
- R5: An edge at which neither strobe nor adv is high leaves addr_out and last_beat unchanged.
- R6: addr_out bits above bit 1 change only at an edge where a strobe is high.
- R7: last_beat is high exactly when the burst is at beat 3, and low right after any load.
- R8: An advance taken at beat 3 wraps to beat 0, so addr_out returns to the starting address and last_beat falls.
- R9: When a strobe and adv are high at the same edge, the load takes effect and the advance is ignored. This holds for both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_cpu | input | 1 | Processor-side burst start strobe, active high |
| ld_ctl | input | 1 | Controller-side burst start strobe, active high |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| start_addr | input | ADDR_W | Starting address of the burst |
| addr_out | output | ADDR_W | Address of the current beat |
| last_beat | output | 1 | High while the final beat of the window is on the bus |

## Verification
A corrupted beat counter appears on the two low bits of addr_out at the first edge after the fault. On the next advance it also sends last_beat high on the wrong beat. A wrong latch of the upper bits or of the low starting bits shows on addr_out straight after the loading edge, and it persists until the next load. Because of this, every beat is compared right after the edge that produced it. Wrap-around is checked by advancing past beat 3 and comparing against the starting address.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
package burst_seq_pkg;
    // Burst ordering selected by the order input.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;
endpackage

// File: rtl/beat_counter.sv
// Beat counter: counts beats within the burst window and wraps around.
// Assumes: load has priority over adv; the counter width sets the window size.
module beat_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [CNT_W-1:0] beat,
    output logic             last
);
    // Next beat: clear on load, otherwise step modulo the window size.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else if (load)
            beat <= '0;
        else if (adv)
            beat <= beat + 1'b1;
    end

    // The final beat is the one where every counter bit is set.
    always_comb last = &beat;
endmodule

// File: rtl/addr_latch.sv
// Start-address register: holds the address captured at burst start.
// Assumes: it is written only by a load strobe.
module addr_latch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] q
);
    // Capture the start address on load; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/order_map.sv
// Order map: turns the start offset and beat number into the low address bits.
// Assumes: order is stable for the duration of a burst.
module order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] base,
    input  logic [CNT_W-1:0] beat,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] low
);
    // Linear order adds with wrap; interleaved order XORs.
    always_comb begin
        case (order)
            ORD_XOR: low = base ^ beat;
            default: low = base + beat;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top. Either strobe loads the full start address.
// adv steps through a 2^CNT_W beat window in linear or interleaved order.
// The upper bits are held from the load.
// Assumes: synchronous active-low reset; order_sel is static during a burst.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_cpu,
    input  logic              ld_ctl,
    input  logic              adv,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last_beat
);
    localparam int UP_W = ADDR_W - CNT_W;

    logic                 load;
    logic [CNT_W-1:0]     beat;
    logic [ADDR_W-1:0]    held;
    logic [CNT_W-1:0]     low;
    burst_order_e         order;

    // Either strobe starts a burst; a load overrides an advance.
    always_comb load  = ld_cpu | ld_ctl;
    // Map the order pin onto the ordering type.
    always_comb order = burst_order_e'(order_sel);

    beat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .beat(beat), .last(last_beat)
    );

    addr_latch #(.ADDR_W(ADDR_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .load(load), .din(start_addr), .q(held)
    );

    order_map #(.CNT_W(CNT_W)) u_map (
        .base(held[CNT_W-1:0]), .beat(beat), .order(order), .low(low)
    );

    // Join the held upper bits with the sequenced low bits.
    always_comb addr_out = {held[ADDR_W-1 -: UP_W], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Checker for burst_addr_seq: temporal properties at the ports.
// Assumes: order_sel is stable while a burst runs.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_cpu,
    input logic              ld_ctl,
    input logic              adv,
    input logic              order_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] addr_out,
    input logic              last_beat
);
    logic ld;
    always_comb ld = ld_cpu | ld_ctl;

    // R2 / R9: a load edge presents the start address and beat 0
    a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (addr_out == $past(start_addr)) && !last_beat);

    // R5: no strobe and no advance leaves the outputs unchanged
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv && $stable(order_sel)) |=> $stable(addr_out) && $stable(last_beat));

    // R6: upper bits change only at a load
    a_r6_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(addr_out[ADDR_W-1:CNT_W]));

    // R3: a linear advance raises the low bits by one, modulo the window
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv && !order_sel) |=>
            (addr_out[CNT_W-1:0] - $past(addr_out[CNT_W-1:0])) == CNT_W'(1));

    // R8: an advance from the last beat wraps, so last_beat falls
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv && last_beat) |=> !last_beat);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_cpu(ld_cpu), .ld_ctl(ld_ctl), .adv(adv),
    .order_sel(order_sel), .start_addr(start_addr), .addr_out(addr_out),
    .last_beat(last_beat)
);

// File: tb/sim_burst_addr_seq.sv
// Directed bench for burst_addr_seq: one task per scenario.
module sim_burst_addr_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_cpu = 1'b0, ld_ctl = 1'b0, adv = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] addr_out;
    logic          last_beat;
    int            n_chk = 0, n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_cpu(ld_cpu), .ld_ctl(ld_ctl), .adv(adv),
        .order_sel(order_sel), .start_addr(start_addr), .addr_out(addr_out),
        .last_beat(last_beat)
    );

    // Compare one value and log any mismatch.
    task automatic check(input string req, input logic [AW:0] act, input logic [AW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected address of beat n, computed from the requirements.
    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int n, input logic ilv);
        logic [1:0] b = s[1:0];
        logic [1:0] nn = n[1:0];
        return {s[AW-1:2], ilv ? (b ^ nn) : (b + nn)};
    endfunction

    // Apply inputs at a falling edge; results are read at the next falling edge.
    task automatic cyc(input logic c, input logic k, input logic a);
        ld_cpu = c; ld_ctl = k; adv = a;
        @(negedge clk);
        ld_cpu = 1'b0; ld_ctl = 1'b0; adv = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        ld_cpu = 1'b1; adv = 1'b1; start_addr = 20'hFFFFF;
        repeat (2) @(negedge clk);
        check("R1 addr in reset", {1'b0, addr_out}, '0);
        check("R1 last in reset", {20'h0, last_beat}, '0);
        ld_cpu = 1'b0; adv = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 addr after release", {1'b0, addr_out}, '0);
    endtask

    // Load, then run four beats plus one wrap.
    task automatic t_burst(input logic [AW-1:0] s, input logic ilv, input logic use_ctl);
        string rq = ilv ? "R4" : "R3";
        order_sel = ilv; start_addr = s;
        cyc(!use_ctl, use_ctl, 1'b0);
        check("R2 load", {1'b0, addr_out}, {1'b0, s});
        check("R7 last after load", {20'h0, last_beat}, '0);
        for (int n = 1; n < 4; n++) begin
            cyc(1'b0, 1'b0, 1'b1);
            check(rq, {1'b0, addr_out}, {1'b0, exp_addr(s, n, ilv)});
            check("R7 last flag", {20'h0, last_beat}, {20'h0, (n == 3)});
        end
        cyc(1'b0, 1'b0, 1'b1);
        check("R8 wrap addr", {1'b0, addr_out}, {1'b0, s});
        check("R8 wrap last", {20'h0, last_beat}, '0);
    endtask

    // Idle cycles keep the current beat.
    task automatic t_hold;
        order_sel = 1'b0; start_addr = 20'hA5A5E;
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        start_addr = 20'h12345;
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        check("R5 hold addr", {1'b0, addr_out}, {1'b0, exp_addr(20'hA5A5E, 1, 1'b0)});
        check("R6 upper kept", {1'b0, addr_out[AW-1:2], 2'b00}, {1'b0, 18'h29697, 2'b00});
    endtask

    // A strobe together with adv loads and does not advance.
    task automatic t_override;
        order_sel = 1'b1; start_addr = 20'h00002;
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        start_addr = 20'hFFFF1;
        cyc(1'b0, 1'b1, 1'b1);
        check("R9 ctl strobe beats adv", {1'b0, addr_out}, {1'b0, 20'hFFFF1});
        cyc(1'b0, 1'b0, 1'b1);
        check("R9 next beat after load", {1'b0, addr_out}, {1'b0, exp_addr(20'hFFFF1, 1, 1'b1)});
        start_addr = 20'h7777B;
        cyc(1'b1, 1'b0, 1'b1);
        check("R9 cpu strobe beats adv", {1'b0, addr_out}, {1'b0, 20'h7777B});
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_burst(20'h3C001, 1'b0, 1'b0);
        t_burst(20'h3C003, 1'b0, 1'b1);
        t_burst(20'h81F02, 1'b1, 1'b0);
        t_burst(20'h81F01, 1'b1, 1'b1);
        t_hold();
        t_override();
        finish_run();
    end
endmodule